// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

A rectangular grid of multiply-accumulate cells that forms the product of a ROWS×DEPTH matrix and a DEPTH×COLS matrix. Each cell owns one element of the result and keeps it in place for the whole run. Only the operands move. Left-edge lanes, one per grid row, carry the elements of an unrolled input window. Top-edge lanes, one per grid column, carry an unrolled filter. Each cell registers the operands it receives and passes them on one cycle later, to the cell on its right and to the cell below.

The caller presents one beat per cycle with all lanes aligned. The block delays row r by r cycles and column c by c cycles, so the pairs that belong together meet in the right cell. A run starts with a start pulse and takes DEPTH beats. After the operands drain through the grid, a done flag rises. The caller then reads the accumulators one grid row per cycle, and the read of the last row ends the run. A mode bit, sampled at start, selects whether the 8-bit operands are read as signed or unsigned.

Top module: `osmm_grid`

## Requirements
- R1: After reset, done is low and every accumulator reads as zero.
- R2: A start pulse while the block is idle does three things: it zeroes all accumulators, it samples signed_mode for the run, and it opens a feed window that begins with the next cycle.
- R3: Each lane has its own valid bit. A cell adds a product only on a cycle when both of its incoming operands are valid. If a lane is invalid on a beat, that beat adds nothing to the results of that lane.
- R4: The bench presents the operands unskewed. Row lane r uses row_dat bits [8r+7:8r] and column lane c uses col_dat bits [8c+7:8c]. After a run, cell (r,c) holds the sum over k of A[r][k]·B[k][c].
- R5: With signed_mode=1 the operands are two's-complement values. With signed_mode=0 they are unsigned.
- R6: Accumulators wrap modulo 2^AW and never saturate.
- R7: done rises at exactly the (ROWS+COLS−2)th clock edge after the edge that accepts the last beat. Idle cycles between beats are allowed and do not count as beats.
- R8: A beat is a cycle inside the feed window on which any lane is valid. The window closes after DEPTH beats, and operand inputs given after that point have no effect.
- R9: rd_data shows grid row rd_row, with column c in bits [c·AW+AW−1:c·AW]. done stays high and the results stay unchanged until rd_en is given with rd_row=ROWS−1. done then falls at the next edge.
- R10: A start pulse given during a feed, a drain or a readout is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (accepted only when idle) |
| signed_mode | input | 1 | 1 = signed operands, 0 = unsigned; sampled at start |
| row_vld | input | ROWS | Per-row operand valid |
| row_dat | input | ROWS·DW | Row operands, lane r at [r·DW +: DW] |
| col_vld | input | COLS | Per-column operand valid |
| col_dat | input | COLS·DW | Column operands, lane c at [c·DW +: DW] |
| done | output | 1 | Results ready for readout |
| rd_en | input | 1 | Readout strobe; strobe on the last row ends the run |
| rd_row | input | RIW | Row index of the readout |
| rd_data | output | COLS·AW | Accumulators of the selected row |

## Verification
Products are checked with operands at the extremes of the range: 0x80 against 0x7F, and 0xFF against 0xFF, each in both modes. A design that sign-extends wrongly, or ignores the mode, gives results that differ by multiples of 2^8. The bench drops a single row lane on one beat and a single column lane on another, and it inserts idle gaps between beats. A cell that gated on only one of its operands, or that counted idle cycles as beats, would then give wrong sums or raise done early. Extra beats are fed after the window closes, and start pulses are given during the feed and during readout, to show that neither changes a result. A second grid of 1×1 cells with 18-bit accumulators overflows on purpose. It exposes saturation, and it also covers the case where there are no drain cycles at all.

// File: rtl/osmm_grid.sv
`timescale 1ns/1ps
module osmm_grid #(
  parameter int ROWS  = 3,
  parameter int COLS  = 3,
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int AW    = 32,
  localparam int RIW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 signed_mode,
  input  logic [ROWS-1:0]      row_vld,
  input  logic [ROWS*DW-1:0]   row_dat,
  input  logic [COLS-1:0]      col_vld,
  input  logic [COLS*DW-1:0]   col_dat,
  output logic                 done,
  input  logic                 rd_en,
  input  logic [RIW-1:0]       rd_row,
  output logic [COLS*AW-1:0]   rd_data
);
  localparam int DRAIN = ROWS + COLS - 2;
  localparam int CW    = $clog2(DEPTH + ROWS + COLS + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_FEED = 2'd1, S_DRAIN = 2'd2, S_DONE = 2'd3;

  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic          sgn;

  wire feeding = (st == S_FEED);
  wire beat    = feeding && ((|row_vld) || (|col_vld));
  wire clr     = (st == S_IDLE) && start;
  wire last_rd = (st == S_DONE) && rd_en && (int'(rd_row) == ROWS - 1);

  assign done = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      sgn <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_FEED;
          cnt <= '0;
          sgn <= signed_mode;
        end
        S_FEED: if (beat) begin
          if (cnt == CW'(DEPTH - 1)) begin
            cnt <= '0;
            st  <= (DRAIN == 0) ? S_DONE : S_DRAIN;
          end else cnt <= cnt + 1'b1;
        end
        S_DRAIN: begin
          if (cnt == CW'(DRAIN - 1)) begin
            cnt <= '0;
            st  <= S_DONE;
          end else cnt <= cnt + 1'b1;
        end
        default: if (last_rd) st <= S_IDLE;
      endcase
    end
  end

  logic [DW:0]   a_edge [ROWS];
  logic [DW:0]   b_edge [COLS];
  logic [DW:0]   a_o    [ROWS][COLS];
  logic [DW:0]   b_o    [ROWS][COLS];
  logic [AW-1:0] acc_o  [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_rsk
    wire [DW:0] raw = {row_vld[r] & feeding, row_dat[r*DW +: DW]};
    if (r == 0) begin : g_thru
      assign a_edge[r] = raw;
    end else begin : g_dly
      logic [DW:0] sh [r];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) for (int k = 0; k < r; k++) sh[k] <= '0;
        else begin
          sh[0] <= raw;
          for (int k = 1; k < r; k++) sh[k] <= sh[k-1];
        end
      end
      assign a_edge[r] = sh[r-1];
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_csk
    wire [DW:0] raw = {col_vld[c] & feeding, col_dat[c*DW +: DW]};
    if (c == 0) begin : g_thru
      assign b_edge[c] = raw;
    end else begin : g_dly
      logic [DW:0] sh [c];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) for (int k = 0; k < c; k++) sh[k] <= '0;
        else begin
          sh[0] <= raw;
          for (int k = 1; k < c; k++) sh[k] <= sh[k-1];
        end
      end
      assign b_edge[c] = sh[c-1];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [DW:0]   ain, bin, aq, bq;
      logic [AW-1:0] acc;
      if (c == 0) begin : g_al
        assign ain = a_edge[r];
      end else begin : g_an
        assign ain = a_o[r][c-1];
      end
      if (r == 0) begin : g_bt
        assign bin = b_edge[c];
      end else begin : g_bn
        assign bin = b_o[r-1][c];
      end
      wire signed [DW:0]     xa   = {sgn & ain[DW-1], ain[DW-1:0]};
      wire signed [DW:0]     xb   = {sgn & bin[DW-1], bin[DW-1:0]};
      wire signed [2*DW+1:0] prod = xa * xb;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          aq  <= '0;
          bq  <= '0;
          acc <= '0;
        end else begin
          aq <= ain;
          bq <= bin;
          if (clr) acc <= '0;
          else if (ain[DW] && bin[DW]) acc <= acc + AW'(prod);
        end
      end
      assign a_o[r][c]   = aq;
      assign b_o[r][c]   = bq;
      assign acc_o[r][c] = acc;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_rd
    assign rd_data[c*AW +: AW] = (int'(rd_row) < ROWS) ? acc_o[rd_row][c] : '0;
  end
endmodule

// File: rtl/osmm_grid_chk.sv
`timescale 1ns/1ps
module osmm_grid_chk #(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  parameter int AW   = 32,
  parameter int RIW  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               done,
  input logic               rd_en,
  input logic [RIW-1:0]     rd_row,
  input logic [COLS*AW-1:0] rd_data,
  input logic [1:0]         st
);
  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && start) |=> (rd_data == '0));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(rd_en && int'(rd_row) == ROWS - 1)) |=> done);

  p_results_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done) && $stable(rd_row)) |-> $stable(rd_data));

  p_done_falls_on_last_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(rd_en && int'(rd_row) == ROWS - 1));
endmodule

bind osmm_grid osmm_grid_chk #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .RIW(RIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .rd_en(rd_en),
  .rd_row(rd_row), .rd_data(rd_data), .st(st)
);

// File: tb/sim_osmm_grid.sv
`timescale 1ns/1ps
module sim_osmm_grid;
  localparam int R = 3, C = 3, T = 4;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic start = 0, signed_mode = 0, rd_en = 0, done;
  logic [R-1:0] row_vld = '0;
  logic [C-1:0] col_vld = '0;
  logic [R*8-1:0] row_dat = '0;
  logic [C*8-1:0] col_dat = '0;
  logic [1:0] rd_row = '0;
  logic [C*32-1:0] rd_data;

  osmm_grid #(.ROWS(R), .COLS(C), .DEPTH(T)) u0 (
    .clk, .rst_n, .start, .signed_mode, .row_vld, .row_dat, .col_vld, .col_dat,
    .done, .rd_en, .rd_row, .rd_data);

  logic s_start = 0, s_mode = 0, s_vld = 0, s_rd_en = 0, s_done;
  logic [7:0] s_a = 0, s_b = 0;
  logic [17:0] s_rd_data;

  osmm_grid #(.ROWS(1), .COLS(1), .DEPTH(8), .AW(18)) u1 (
    .clk, .rst_n, .start(s_start), .signed_mode(s_mode), .row_vld(s_vld), .row_dat(s_a),
    .col_vld(s_vld), .col_dat(s_b), .done(s_done), .rd_en(s_rd_en), .rd_row(1'b0),
    .rd_data(s_rd_data));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // {mode, pattern[1:0], seed[7:0]}
  localparam logic [10:0] TBL [6] = '{
    {1'b0, 2'd0, 8'd5}, {1'b1, 2'd0, 8'd9}, {1'b0, 2'd2, 8'd0},
    {1'b1, 2'd2, 8'd0}, {1'b1, 2'd1, 8'd0}, {1'b0, 2'd1, 8'd0}};

  logic [7:0] A [R][T];
  logic [7:0] B [T][C];
  int g_drop_r, g_drop_c, g_drop_rk, g_drop_ck, g_extra, g_gap, g_poke;

  task automatic run_case(input logic m, input string tag);
    logic [31:0] ex [R][C];
    int n;
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) begin
      ex[r][c] = 0;
      for (int k = 0; k < T; k++) begin
        logic [31:0] xa, xb;
        xa = m ? {{24{A[r][k][7]}}, A[r][k]} : {24'd0, A[r][k]};
        xb = m ? {{24{B[k][c][7]}}, B[k][c]} : {24'd0, B[k][c]};
        if (!(r == g_drop_r && k == g_drop_rk) && !(c == g_drop_c && k == g_drop_ck))
          ex[r][c] = ex[r][c] + xa * xb;
      end
    end
    @(posedge clk); #1 start = 1; signed_mode = m;
    @(posedge clk); #1 start = 0;
    for (int k = 0; k < T + g_extra; k++) begin
      for (int r = 0; r < R; r++) begin
        row_dat[r*8 +: 8] = (k < T) ? A[r][k] : 8'hFF;
        row_vld[r] = !(r == g_drop_r && k == g_drop_rk);
      end
      for (int c = 0; c < C; c++) begin
        col_dat[c*8 +: 8] = (k < T) ? B[k][c] : 8'hFF;
        col_vld[c] = !(c == g_drop_c && k == g_drop_ck);
      end
      start = (g_poke != 0 && k == 1);
      @(posedge clk); #1 start = 0;
      if (g_gap != 0 && k < T - 1) begin
        row_vld = '0; col_vld = '0;
        @(posedge clk); #1;
      end
    end
    row_vld = '0; col_vld = '0;
    n = 0;
    while (!done && n < 40) begin @(posedge clk); #1 n++; end
    if (g_extra == 0) chk(n == R + C - 2, {"R7 done latency ", tag}, n, R + C - 2);
    if (g_poke != 0) begin
      start = 1; @(posedge clk); #1 start = 0;
      chk(done == 1'b1, {"R10 start in readout ", tag}, done, 1);
    end
    for (int r = 0; r < R; r++) begin
      rd_row = 2'(r); rd_en = (r == R - 1);
      #1;
      for (int c = 0; c < C; c++)
        chk(rd_data[c*32 +: 32] === ex[r][c], {"R4/R5/R3/R8/R10 result ", tag}, rd_data[c*32 +: 32], ex[r][c]);
      @(posedge clk); #1 rd_en = 0;
    end
    chk(done == 1'b0, {"R9 done falls ", tag}, done, 0);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(rd_data == '0, "R1 accumulators after reset", rd_data[31:0], 0);

    foreach (TBL[i]) begin
      logic m; logic [1:0] pat; logic [7:0] sd;
      {m, pat, sd} = TBL[i];
      for (int r = 0; r < R; r++) for (int k = 0; k < T; k++)
        A[r][k] = (pat == 0) ? 8'(sd * 37 + r * 71 + k * 13 + 200) : (pat == 1) ? 8'h80 : 8'hFF;
      for (int k = 0; k < T; k++) for (int c = 0; c < C; c++)
        B[k][c] = (pat == 0) ? 8'(sd * 53 + k * 29 + c * 97 + 11) : (pat == 1) ? 8'h7F : 8'hFF;
      g_drop_r = (i == 0) ? 1 : -1;  g_drop_rk = 2;
      g_drop_c = (i == 0) ? 2 : -1;  g_drop_ck = 0;
      g_poke   = (i == 1) ? 1 : 0;
      g_gap    = (i == 3) ? 1 : 0;
      g_extra  = (i == 4) ? 2 : 0;
      run_case(m, $sformatf("vec%0d", i));
    end

    // R6 wrap and R7 zero-drain on the 1x1 grid with 18-bit sums
    for (int pass = 0; pass < 2; pass++) begin
      @(posedge clk); #1 s_start = 1; s_mode = (pass == 1);
      @(posedge clk); #1 s_start = 0;
      s_a = (pass == 1) ? 8'h80 : 8'hFF;
      s_b = s_a;
      s_vld = 1;
      repeat (8) begin @(posedge clk); #1; end
      s_vld = 0;
      chk(s_done == 1'b1, "R7 done with no drain", s_done, 1);
      chk(s_rd_data == ((pass == 1) ? 18'd131072 : 18'd258056), "R6 wrap modulo 2^AW",
          {14'd0, s_rd_data}, (pass == 1) ? 32'd131072 : 32'd258056);
      s_rd_en = 1; @(posedge clk); #1 s_rd_en = 0;
      chk(s_done == 1'b0, "R9 done falls 1x1", s_done, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule